// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block translates virtual addresses through a fully associative table of translation entries. Each entry can use any of eight page sizes, so the block can map large regions with one entry and small regions with fine granularity. A lookup is purely combinational. In the same cycle, the block compares the virtual address against every entry, applies the process-ID filter and the zone permission override, and returns a result. The result is a hit, a miss or a protection error. It comes with the matching entry's index, the page base, the real page and the final physical address.

Each entry holds a tag word, a data word and an 8-bit translation ID. They are loaded through an indexed write port, and an indexed read port returns them. When a tag word is written, the write also captures the translation ID from the current process ID. A separate zone resolver, one copy per entry, turns a 32-bit zone configuration word and the entry's zone select into effective write and execute rights. The same resolver can also hide the entry from user-mode lookups.

Top module: `vpage_tlb`

## Requirements
- R1: After reset, every entry is invalid: all tag words read back as zero and every lookup returns MISS.
- R2: A write with `wrSel`=0 stores `wrData` as the tag word of entry `wrIdx` and stores `wrPid` as its translation ID. A write with `wrSel`=1 stores the data word and leaves the translation ID unchanged. The stored values are visible on the read port from the next cycle (`rdSel`=0 gives the tag, `rdSel`=1 gives the data).
- R3: Tag word layout: [31:10] page number, [9:7] size code, [6] valid. Size code n selects a page of 1024·4^n bytes (1 KB up to 16 MB). An entry matches when it is valid and the virtual address equals the tag word on every bit at or above log2(size).
- R4: An entry with translation ID 0 matches any `lkPid`. An entry with a nonzero translation ID matches only when that ID equals `lkPid`.
- R5: When several entries qualify, the one with the lowest index is chosen.
- R6: Data word layout: [31:10] real page, [9] execute enable, [8] write enable, [7:4] zone select z. The zone code is `zoneCfg[31-2z:30-2z]`:
  - Code 0: the entry is skipped for user lookups, and the search continues with higher indices. Supervisor lookups use the entry's own bits.
  - Code 1: the entry's own bits apply.
  - Code 2: supervisor lookups get write and execute; user lookups use the entry's own bits.
  - Code 3: write and execute are always granted.
- R7: Access codes are 0 read, 1 write and 2 fetch. A read is always permitted. If the chosen entry lacks effective write rights for a write, or effective execute rights for a fetch, the result is PROT and no later entry is tried.
- R8: Result codes are 0 MISS, 1 HIT and 2 PROT. On HIT or PROT, the block reports the following from the chosen entry:
  - `lkIndex`: the entry index.
  - `lkSizeCode`: the size code.
  - `lkPageBase`: the tag word with bits below the page size cleared.
  - `lkRealPage`: the real page, with bits below the page size cleared.
- R9: On HIT, `lkPaddr` is the real page in the bits at and above the page size, combined with the virtual-address bits below the page size. On PROT, `lkPaddr` is 0.
- R10: On MISS, `lkIndex`, `lkPageBase`, `lkRealPage`, `lkSizeCode` and `lkPaddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Entry write strobe |
| wrSel | input | 1 | 0 writes the tag word (and the translation ID), 1 writes the data word |
| wrIdx | input | IDX_W | Entry index for writes |
| wrData | input | 32 | Word to write |
| wrPid | input | 8 | Translation ID captured on a tag write |
| rdIdx | input | IDX_W | Entry index for reads |
| rdSel | input | 1 | 0 reads the tag word, 1 reads the data word |
| rdData | output | 32 | Word read |
| rdTid | output | 8 | Translation ID of entry `rdIdx` |
| zoneCfg | input | 32 | Zone configuration, two bits per zone |
| lkVaddr | input | 32 | Virtual address to translate |
| lkAccess | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lkUser | input | 1 | 1 for a user-mode lookup |
| lkPid | input | 8 | Current process ID |
| lkResult | output | 2 | 0 MISS, 1 HIT, 2 PROT |
| lkIndex | output | IDX_W | Chosen entry index |
| lkPageBase | output | 32 | Masked tag page base |
| lkRealPage | output | 32 | Masked real page |
| lkSizeCode | output | 3 | Size code of the chosen entry |
| lkPaddr | output | 32 | Translated physical address |

## Verification
Several properties are checked on every clock edge:
- the read port returns the word written in the previous cycle;
- a miss drives all result fields to zero, and a protection error drives the physical address to zero;
- a hit keeps the virtual-address bits below the reported page size and agrees with the page base above it;
- no undefined result code appears.

Other behaviours can be seen only in the bench's scenarios:
- choosing the lowest qualifying index;
- skipping a user-hidden entry in favour of a later one;
- stopping at the first permitted entry that then fails its check;
- process-ID filtering;
- the size sweep and the full sweep over zone code, mode, access type and entry rights.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int WORD_W = 32;
  localparam int TID_W = 8;
  localparam int MAX_IDX_W = 8;

  typedef enum logic [1:0] {
    RES_MISS = 2'd0,
    RES_HIT  = 2'd1,
    RES_PROT = 2'd2
  } lkRes_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // bit positions shared by the entry store and the result logic
  localparam int TAG_SIZE_LO = 7;
  localparam int TAG_VALID   = 6;
  localparam int DAT_EXEC    = 9;
  localparam int DAT_WRITE   = 8;
  localparam int DAT_ZONE_LO = 4;

  typedef struct packed {
    logic                 tagWe;
    logic                 dataWe;
    logic [MAX_IDX_W-1:0] idx;
  } storeStrobe_t;

  // ones in every bit that lies below the page size
  function automatic logic [WORD_W-1:0] offsetMask(input logic [2:0] code);
    logic [WORD_W-1:0] span;
    span = WORD_W'(32'h400) << {code, 1'b0};
    return span - WORD_W'(1);
  endfunction
endpackage

// File: rtl/vtlb_zone.sv
module vtlb_zone
  import vtlb_pkg::*;
#(
  parameter int ZONES = 16
) (
  input  logic [WORD_W-1:0] zoneCfg,
  input  logic [3:0]        zoneSel,
  input  logic              isUser,
  input  logic              entWr,
  input  logic              entEx,
  output logic              hideEntry,
  output logic              effWr,
  output logic              effEx
);
  logic [1:0]        zoneCode;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = zoneCfg >> (5'd30 - {zoneSel, 1'b0});
    if (int'(zoneSel) < ZONES) zoneCode = shifted[1:0];
    else zoneCode = 2'd1;
    hideEntry = 1'b0;
    effWr = entWr;
    effEx = entEx;
    unique case (zoneCode)
      2'd0: hideEntry = isUser;
      2'd1: ;
      2'd2: if (!isUser) begin
        effWr = 1'b1;
        effEx = 1'b1;
      end
      default: begin
        effWr = 1'b1;
        effEx = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ZONES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  storeStrobe_t       strobe,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [TID_W-1:0]   wrPid,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic               rdSel,
  output logic [WORD_W-1:0]  rdData,
  output logic [TID_W-1:0]   rdTid,
  input  logic [WORD_W-1:0]  zoneCfg,
  input  logic [WORD_W-1:0]  lkVaddr,
  input  logic               lkUser,
  input  logic [TID_W-1:0]   lkPid,
  input  logic [IDX_W-1:0]   selIdx,
  output logic [ENTRIES-1:0] qualVec,
  output logic [ENTRIES-1:0] effWrVec,
  output logic [ENTRIES-1:0] effExVec,
  output logic [WORD_W-1:0]  selTag,
  output logic [WORD_W-1:0]  selData
);
  logic [WORD_W-1:0] tagMem  [ENTRIES];
  logic [WORD_W-1:0] dataMem [ENTRIES];
  logic [TID_W-1:0]  tidMem  [ENTRIES];
  logic [IDX_W-1:0]  wIdx;

  assign wIdx = strobe.idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i]  <= '0;
        dataMem[i] <= '0;
        tidMem[i]  <= '0;
      end
    end else begin
      if (strobe.tagWe) begin
        tagMem[wIdx] <= wrData;
        tidMem[wIdx] <= wrPid;
      end
      if (strobe.dataWe) dataMem[wIdx] <= wrData;
    end
  end

  assign rdData  = rdSel ? dataMem[rdIdx] : tagMem[rdIdx];
  assign rdTid   = tidMem[rdIdx];
  assign selTag  = tagMem[selIdx];
  assign selData = dataMem[selIdx];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [WORD_W-1:0] pageMask;
    logic addrHit, tidOk, hide;

    assign pageMask = ~offsetMask(tagMem[g][TAG_SIZE_LO +: 3]);
    assign addrHit  = ((lkVaddr ^ tagMem[g]) & pageMask) == '0;
    assign tidOk    = (tidMem[g] == '0) || (tidMem[g] == lkPid);

    vtlb_zone #(.ZONES(ZONES)) uZone (
      .zoneCfg  (zoneCfg),
      .zoneSel  (dataMem[g][DAT_ZONE_LO +: 4]),
      .isUser   (lkUser),
      .entWr    (dataMem[g][DAT_WRITE]),
      .entEx    (dataMem[g][DAT_EXEC]),
      .hideEntry(hide),
      .effWr    (effWrVec[g]),
      .effEx    (effExVec[g])
    );

    assign qualVec[g] = tagMem[g][TAG_VALID] & addrHit & tidOk & ~hide;
  end
endmodule

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [IDX_W-1:0]   wrIdx,
  output storeStrobe_t       strobe,
  input  logic [ENTRIES-1:0] qualVec,
  input  logic [ENTRIES-1:0] effWrVec,
  input  logic [ENTRIES-1:0] effExVec,
  output logic [IDX_W-1:0]   selIdx,
  input  logic [WORD_W-1:0]  selTag,
  input  logic [WORD_W-1:0]  selData,
  input  logic [WORD_W-1:0]  lkVaddr,
  input  logic [1:0]         lkAccess,
  output logic [1:0]         lkResult,
  output logic [IDX_W-1:0]   lkIndex,
  output logic [WORD_W-1:0]  lkPageBase,
  output logic [WORD_W-1:0]  lkRealPage,
  output logic [2:0]         lkSizeCode,
  output logic [WORD_W-1:0]  lkPaddr
);
  logic              found, denied;
  logic [WORD_W-1:0] offMask;
  lkRes_e            res;

  always_comb begin
    strobe.tagWe  = wrEn & ~wrSel;
    strobe.dataWe = wrEn & wrSel;
    strobe.idx    = MAX_IDX_W'(wrIdx);
  end

  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (qualVec[i]) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    offMask = offsetMask(selTag[TAG_SIZE_LO +: 3]);
    denied  = ((lkAccess == ACC_WRITE) && !effWrVec[selIdx]) ||
              ((lkAccess == ACC_FETCH) && !effExVec[selIdx]);
    if (!found) res = RES_MISS;
    else if (denied) res = RES_PROT;
    else res = RES_HIT;

    lkResult   = res;
    lkIndex    = '0;
    lkPageBase = '0;
    lkRealPage = '0;
    lkSizeCode = '0;
    lkPaddr    = '0;
    if (found) begin
      lkIndex    = selIdx;
      lkPageBase = selTag & ~offMask;
      lkRealPage = selData & ~offMask;
      lkSizeCode = selTag[TAG_SIZE_LO +: 3];
      if (res == RES_HIT) lkPaddr = (selData & ~offMask) | (lkVaddr & offMask);
    end
  end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ZONES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [31:0]       wrData,
  input  logic [7:0]        wrPid,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              rdSel,
  output logic [31:0]       rdData,
  output logic [7:0]        rdTid,
  input  logic [31:0]       zoneCfg,
  input  logic [31:0]       lkVaddr,
  input  logic [1:0]        lkAccess,
  input  logic              lkUser,
  input  logic [7:0]        lkPid,
  output logic [1:0]        lkResult,
  output logic [IDX_W-1:0]  lkIndex,
  output logic [31:0]       lkPageBase,
  output logic [31:0]       lkRealPage,
  output logic [2:0]        lkSizeCode,
  output logic [31:0]       lkPaddr
);
  storeStrobe_t       strobe;
  logic [ENTRIES-1:0] qualVec, effWrVec, effExVec;
  logic [IDX_W-1:0]   selIdx;
  logic [WORD_W-1:0]  selTag, selData;

  initial begin
    if (ENTRIES > (1 << MAX_IDX_W)) $display("vpage_tlb: ENTRIES exceeds index field");
  end

  vtlb_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx), .strobe(strobe),
    .qualVec(qualVec), .effWrVec(effWrVec), .effExVec(effExVec),
    .selIdx(selIdx), .selTag(selTag), .selData(selData),
    .lkVaddr(lkVaddr), .lkAccess(lkAccess),
    .lkResult(lkResult), .lkIndex(lkIndex), .lkPageBase(lkPageBase),
    .lkRealPage(lkRealPage), .lkSizeCode(lkSizeCode), .lkPaddr(lkPaddr)
  );

  vtlb_store #(.ENTRIES(ENTRIES), .ZONES(ZONES)) uStore (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData), .wrPid(wrPid),
    .rdIdx(rdIdx), .rdSel(rdSel), .rdData(rdData), .rdTid(rdTid),
    .zoneCfg(zoneCfg), .lkVaddr(lkVaddr), .lkUser(lkUser), .lkPid(lkPid),
    .selIdx(selIdx), .qualVec(qualVec), .effWrVec(effWrVec),
    .effExVec(effExVec), .selTag(selTag), .selData(selData)
  );
endmodule

// File: rtl/vtlb_chk.sv
module vtlb_chk #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             wrSel,
  input logic [IDX_W-1:0] wrIdx,
  input logic [31:0]      wrData,
  input logic [IDX_W-1:0] rdIdx,
  input logic             rdSel,
  input logic [31:0]      rdData,
  input logic [31:0]      lkVaddr,
  input logic [1:0]       lkResult,
  input logic [IDX_W-1:0] lkIndex,
  input logic [31:0]      lkPageBase,
  input logic [31:0]      lkRealPage,
  input logic [2:0]       lkSizeCode,
  input logic [31:0]      lkPaddr
);
  logic [31:0] lowBits;
  assign lowBits = (32'd1024 << (2 * lkSizeCode)) - 32'd1;

  // R2: a word written last cycle is returned by the read port
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(wrEn) && !$past(rst) && (rdSel == $past(wrSel)) && (rdIdx == $past(wrIdx)))
      |-> (rdData == $past(wrData)));

  // R1: the first cycle after reset finds nothing
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lkResult == 2'd0));

  // R9: a hit keeps the offset bits of the virtual address
  a_r9_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (lkResult == 2'd1) |-> (((lkPaddr ^ lkVaddr) & lowBits) == 32'd0));

  // R3: a hit agrees with the page base above the page size
  a_r3_base_match: assert property (@(posedge clk) disable iff (rst)
    (lkResult == 2'd1) |-> (((lkPageBase ^ lkVaddr) & ~lowBits) == 32'd0));

  // R10: a miss leaves every result field at zero
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (lkResult == 2'd0) |-> ((lkPaddr | lkPageBase | lkRealPage) == 32'd0 &&
                            lkIndex == '0 && lkSizeCode == 3'd0));

  // R8: only the three defined result codes appear
  a_r8_code_legal: assert property (@(posedge clk) disable iff (rst)
    lkResult != 2'd3);

  // R9: a protection error reports no physical address
  a_r9_prot_no_addr: assert property (@(posedge clk) disable iff (rst)
    (lkResult == 2'd2) |-> (lkPaddr == 32'd0));
endmodule

bind vpage_tlb vtlb_chk #(.ENTRIES(ENTRIES)) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
  .wrData(wrData), .rdIdx(rdIdx), .rdSel(rdSel), .rdData(rdData),
  .lkVaddr(lkVaddr), .lkResult(lkResult), .lkIndex(lkIndex),
  .lkPageBase(lkPageBase), .lkRealPage(lkRealPage),
  .lkSizeCode(lkSizeCode), .lkPaddr(lkPaddr)
);

// File: tb/tb_vpage_tlb.sv
`timescale 1ns/1ps
module tb_vpage_tlb;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst = 1;
  logic wrEn = 0, wrSel = 0, rdSel = 0, lkUser = 0;
  logic [IW-1:0] wrIdx = 0, rdIdx = 0;
  logic [31:0] wrData = 0, zoneCfg = 0, lkVaddr = 0;
  logic [7:0] wrPid = 0, lkPid = 0;
  logic [1:0] lkAccess = 0;
  logic [31:0] rdData, lkPageBase, lkRealPage, lkPaddr;
  logic [7:0] rdTid;
  logic [1:0] lkResult;
  logic [IW-1:0] lkIndex;
  logic [2:0] lkSizeCode;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vpage_tlb #(.ENTRIES(N)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit sel, input logic [31:0] d, input logic [7:0] pid);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrIdx = IW'(idx); wrData = d; wrPid = pid;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic entry(input int idx, input logic [31:0] tag, input logic [31:0] dat,
                       input logic [7:0] pid);
    wr(idx, 1'b1, dat, 8'h00);
    wr(idx, 1'b0, tag, pid);
  endtask

  task automatic clearAll();
    for (int i = 0; i < N; i++) wr(i, 1'b0, 32'h0, 8'h00);
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input bit usr,
                      input logic [7:0] pid);
    lkVaddr = va; lkAccess = acc; lkUser = usr; lkPid = pid;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1: empty after reset
    look(32'h1234_5678, 2'd0, 0, 8'h00);
    chk("R1 result", 32'(lkResult), 0);
    chk("R10 paddr", lkPaddr, 0);
    for (int i = 0; i < N; i++) begin
      rdIdx = IW'(i); rdSel = 0; #1;
      chk("R1 tag", rdData, 0);
    end

    // R2: write and read back, tid capture
    entry(4, 32'hABCD_E4C0, 32'h1357_9BD0, 8'h5A);
    rdIdx = 4; rdSel = 0; #1;
    chk("R2 tag", rdData, 32'hABCD_E4C0);
    chk("R2 tid", 32'(rdTid), 32'h5A);
    rdSel = 1; #1;
    chk("R2 data", rdData, 32'h1357_9BD0);
    wr(4, 1'b1, 32'h2222_2000, 8'h77);
    #1;
    chk("R2 data rewrite", rdData, 32'h2222_2000);
    chk("R2 tid kept", 32'(rdTid), 32'h5A);
    clearAll();

    // R3: size sweep, zone code 1 everywhere
    zoneCfg = 32'h5555_5555;
    for (int c = 0; c < 8; c++) begin
      logic [31:0] sz, base, rpn;
      sz = 32'd1024 << (2 * c);
      base = 32'h4000_0000;
      rpn = 32'h8000_0000;
      entry(0, base | (32'(c) << 7) | 32'h40, rpn | 32'h300, 8'h00);
      look(base + sz - 4, 2'd0, 0, 8'h00);
      chk("R3 in-page hit", 32'(lkResult), 1);
      chk("R9 paddr", lkPaddr, rpn | (sz - 4));
      chk("R8 base", lkPageBase, base);
      chk("R8 rpn", lkRealPage, rpn);
      chk("R8 size", 32'(lkSizeCode), 32'(c));
      look(base + sz, 2'd0, 0, 8'h00);
      chk("R3 past end miss", 32'(lkResult), 0);
      chk("R10 miss zeros", lkPageBase | lkRealPage | 32'(lkIndex), 0);
      look(base - 4, 2'd0, 0, 8'h00);
      chk("R3 below miss", 32'(lkResult), 0);
    end
    clearAll();

    // R4: translation ID filter
    entry(0, 32'h1000_0000 | (1 << 7) | 32'h40, 32'h0300_0300, 8'h12);
    look(32'h1000_0010, 2'd0, 0, 8'h12);
    chk("R4 tid equal", 32'(lkResult), 1);
    look(32'h1000_0010, 2'd0, 0, 8'h13);
    chk("R4 tid differ", 32'(lkResult), 0);
    wr(0, 1'b0, 32'h1000_0000 | (1 << 7) | 32'h40, 8'h00);
    look(32'h1000_0010, 2'd0, 0, 8'h77);
    chk("R4 tid zero any", 32'(lkResult), 1);
    clearAll();

    // R5: lowest index wins
    entry(2, 32'h2000_0000 | (1 << 7) | 32'h40, 32'h0AA0_0300, 8'h00);
    entry(5, 32'h2000_0000 | (1 << 7) | 32'h40, 32'h0BB0_0300, 8'h00);
    look(32'h2000_0123, 2'd0, 0, 8'h00);
    chk("R5 first idx", 32'(lkIndex), 2);
    chk("R5 first paddr", lkPaddr, 32'h0AA0_0123);
    wr(2, 1'b0, 32'h0, 8'h00);
    look(32'h2000_0123, 2'd0, 0, 8'h00);
    chk("R5 next idx", 32'(lkIndex), 5);
    entry(7, 32'h3000_0000 | 32'h40, 32'h0CC0_0300, 8'h00);
    look(32'h3000_03FC, 2'd0, 0, 8'h00);
    chk("R5 top idx", 32'(lkIndex), 7);
    clearAll();

    // R6: hidden entry skipped for user; R7: first entry stops on denial
    zoneCfg = 32'h1000_0000;   // zone0 code 0, zone1 code 1
    entry(1, 32'h5000_0000 | (1 << 7) | 32'h40, 32'h0110_0300, 8'h00);
    entry(3, 32'h5000_0000 | (1 << 7) | 32'h40, 32'h0330_0310, 8'h00);
    look(32'h5000_0044, 2'd0, 1, 8'h00);
    chk("R6 user skips", 32'(lkIndex), 3);
    chk("R6 user hit", 32'(lkResult), 1);
    look(32'h5000_0044, 2'd0, 0, 8'h00);
    chk("R6 sup uses first", 32'(lkIndex), 1);
    wr(1, 1'b1, 32'h0110_0210, 8'h00);  // zone1, exec only
    look(32'h5000_0044, 2'd1, 0, 8'h00);
    chk("R7 prot stops", 32'(lkResult), 2);
    chk("R7 prot idx", 32'(lkIndex), 1);
    chk("R9 prot paddr", lkPaddr, 0);
    look(32'h5000_0044, 2'd0, 0, 8'h00);
    chk("R7 read ok", 32'(lkResult), 1);
    clearAll();

    // R6/R7 sweep: zone 3 on entry 0
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 4; e++) begin
        bit ew, ex;
        ew = e[0]; ex = e[1];
        zoneCfg = 32'(c) << 24;
        entry(0, 32'h6000_0000 | (2 << 7) | 32'h40,
              32'h0660_0030 | (32'(ex) << 9) | (32'(ew) << 8), 8'h00);
        for (int u = 0; u < 2; u++)
          for (int a = 0; a < 3; a++) begin
            bit fw, fx;
            int expRes;
            fw = (c == 3 || (c == 2 && u == 0)) ? 1'b1 : ew;
            fx = (c == 3 || (c == 2 && u == 0)) ? 1'b1 : ex;
            if (c == 0 && u == 1) expRes = 0;
            else if ((a == 1 && !fw) || (a == 2 && !fx)) expRes = 2;
            else expRes = 1;
            look(32'h6000_0100, 2'(a), u[0], 8'h00);
            chk("R7 zone sweep", 32'(lkResult), 32'(expRes));
          end
      end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule